// File: doc/BRIEF.md
# Local Bus Cycle Sequencer

This block turns a word-count request into local-bus data cycles for a single address space. The requester gives a start byte address, a direction and a number of 32-bit words. The sequencer then drives an address strobe, the address, a data-valid level and a last-beat flag. It paces each data phase with a programmed number of internal wait states. It can also wait for an external ready input and can end a burst early on an external burst-terminate input. Moving data between byte lanes is handled outside the block.

Five settings shape the bus cycles: the port width, the wait-state count, the ready enable, the terminate enable and the burst enable. These settings are captured when a request is accepted. With a narrow port, each 32-bit word becomes two or four beats at incrementing byte addresses. With terminate handling off, no burst covers more than four words, and longer requests are split. With bursting off, every beat gets its own address phase. For each beat, the requester offers or takes data through a valid level and a per-word acknowledge. A one-cycle done pulse closes each request.

Top module: `lbus_cycle_seq`

## Requirements
- R1: `cfg_width` selects the beat size: 00 gives four 1-byte beats per word, 01 gives two 2-byte beats, and 10 or 11 gives one 4-byte beat. `lb_addr` starts at `req_addr` and advances by the beat size after every beat.
- R2: A data phase (`lb_dv` high) lasts at least `cfg_wait`+1 cycles. Its first `cfg_wait` cycles never complete it.
- R3: With the ready enable at 1, a data phase completes only in a cycle where `lb_rdy` is high and the wait count has run out. With the ready enable at 0, `lb_rdy` is ignored.
- R4: With bursting on and terminate handling off, one address phase carries at most four words' worth of beats. A longer request gets a new `lb_ads` after each such group.
- R5: With terminate handling on, burst length is unbounded. If `lb_bterm` is high in the cycle a beat completes, the next cycle is a new address phase for the remaining words. With terminate handling off, `lb_bterm` has no effect.
- R6: With bursting off, every beat is preceded by its own one-cycle `lb_ads`. Each address phase is followed directly by its data phase.
- R7: `lb_last` is high during a data phase exactly when that beat is the final beat of the request, the bursting is off, or the beat is the last one the four-word limit allows.
- R8: A data phase completes only while `usr_valid` is high. `usr_ack` pulses for one cycle in the cycle the final beat of each 32-bit word completes.
- R9: `req_ready` is high only while idle. `done` pulses for one cycle, in the cycle after the last beat completes. A request of zero words produces `done` in the cycle after acceptance, with no `lb_ads`.
- R10: The settings and direction are taken when the request is accepted. Changing the `cfg_*` inputs while busy has no effect on the cycles of that request.
- R11: After reset, `req_ready` is 1 and `lb_ads`, `lb_dv`, `lb_last`, `usr_ack` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Port width code |
| cfg_wait | input | WW | Wait states per data phase |
| cfg_rdy_en | input | 1 | Honour `lb_rdy` |
| cfg_bterm_en | input | 1 | Honour `lb_bterm`, removes the four-word limit |
| cfg_burst_en | input | 1 | Allow multi-beat bus cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | AW | Start byte address |
| req_write | input | 1 | Direction, 1 = write |
| req_words | input | CW | Number of 32-bit words |
| usr_valid | input | 1 | Requester can supply or take a beat |
| usr_ack | output | 1 | A 32-bit word finished |
| lb_ads | output | 1 | Address strobe |
| lb_addr | output | AW | Current byte address |
| lb_write | output | 1 | Direction of the current request |
| lb_dv | output | 1 | Data phase in progress |
| lb_last | output | 1 | Final beat of this bus cycle |
| lb_rdy | input | 1 | External ready |
| lb_bterm | input | 1 | External burst terminate |
| done | output | 1 | Request finished |

## Verification
All outputs are combinational from registered state plus the current `lb_rdy`, `lb_bterm` and `usr_valid`. A stimulus applied in one cycle therefore shows up at the next clock edge:
- `lb_ads` appears one cycle after acceptance.
- The first data phase follows one cycle later and ends no sooner than `cfg_wait` cycles after that.
- `done` follows one cycle after the last beat completes.

Inputs change two time units after each rising edge, and the bench compares every output at the falling edge, against a behavioural model stepped with those same inputs. Whole-request checks then count address strobes to confirm the burst splits.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2,
      ST_FIN  = 2'd3
   } lbs_state_e;

   // beats needed to move one 32-bit word
   function automatic logic [2:0] beats_per_word(input logic [1:0] w);
      case (w)
         2'b00:   beats_per_word = 3'd4;
         2'b01:   beats_per_word = 3'd2;
         default: beats_per_word = 3'd1;
      endcase
   endfunction

   // byte address advance per beat
   function automatic logic [2:0] bytes_per_beat(input logic [1:0] w);
      case (w)
         2'b00:   bytes_per_beat = 3'd1;
         2'b01:   bytes_per_beat = 3'd2;
         default: bytes_per_beat = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/lbs_wait_timer.sv
module lbs_wait_timer #(
   parameter int WW      = 4,
   parameter bit WAIT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [WW-1:0] load_val,
   output logic          expired
);

   if (WW < 1) begin : g_bad_ww
      $error("lbs_wait_timer: WW must be at least 1");
   end

   if (WAIT_EN) begin : g_cnt
      logic [WW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (load)
            cnt <= load_val;
         else if (cnt != '0)
            cnt <= cnt - WW'(1);
      end

      assign expired = (cnt == '0);

      // R2: a freshly loaded nonzero count holds the phase for a cycle
      assert_load_holds_R2 : assert property (@(posedge clk) disable iff (!rst_n)
         (load && load_val != '0) |=> !expired);
   end else begin : g_none
      logic unused_tie;
      assign unused_tie = &{1'b0, clk, rst_n, load, load_val};
      assign expired    = 1'b1;
   end

endmodule

// File: rtl/lbs_beat_track.sv
module lbs_beat_track
   import lbs_pkg::*;
#(
   parameter int AW  = 32,
   parameter int CW  = 8,
   parameter int BCW = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [AW-1:0]  start_addr,
   input  logic [CW-1:0]  start_words,
   input  logic [1:0]     width,
   input  logic           beat_done,
   input  logic           new_cycle,
   output logic [AW-1:0]  cur_addr,
   output logic           last_beat_word,
   output logic           last_beat_all,
   output logic [BCW-1:0] burst_beats
);

   logic [1:0]    bidx;
   logic [CW-1:0] wleft;
   logic [2:0]    bpw;
   logic [2:0]    step;

   assign bpw  = beats_per_word(width);
   assign step = bytes_per_beat(width);

   assign last_beat_word = ({1'b0, bidx} == (bpw - 3'd1));
   assign last_beat_all  = last_beat_word && (wleft == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr    <= '0;
         bidx        <= '0;
         wleft       <= '0;
         burst_beats <= '0;
      end else if (start) begin
         cur_addr    <= start_addr;
         bidx        <= '0;
         wleft       <= start_words;
         burst_beats <= '0;
      end else if (beat_done) begin
         cur_addr    <= cur_addr + AW'(step);
         bidx        <= last_beat_word ? 2'd0 : bidx + 2'd1;
         if (last_beat_word)
            wleft <= wleft - CW'(1);
         burst_beats <= new_cycle ? '0 : burst_beats + BCW'(1);
      end
   end

   // R9: no beat is ever taken once the word count is used up
   assert_words_left_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      beat_done |-> (wleft != '0));

   // R1: address moves by exactly one beat size per completed beat
   assert_addr_step_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (beat_done && !start) |=> (cur_addr == $past(cur_addr) + AW'($past(step))));

endmodule

// File: rtl/lbus_cycle_seq.sv
module lbus_cycle_seq
   import lbs_pkg::*;
#(
   parameter int AW          = 32,
   parameter int CW          = 8,
   parameter int WW          = 4,
   parameter int BURST_WORDS = 4,
   parameter bit WAIT_EN     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cfg_width,
   input  logic [WW-1:0] cfg_wait,
   input  logic          cfg_rdy_en,
   input  logic          cfg_bterm_en,
   input  logic          cfg_burst_en,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic          req_write,
   input  logic [CW-1:0] req_words,
   input  logic          usr_valid,
   output logic          usr_ack,
   output logic          lb_ads,
   output logic [AW-1:0] lb_addr,
   output logic          lb_write,
   output logic          lb_dv,
   output logic          lb_last,
   input  logic          lb_rdy,
   input  logic          lb_bterm,
   output logic          done
);

   localparam int MAX_BEATS = BURST_WORDS * 4;
   localparam int BCW       = $clog2(MAX_BEATS + 1);

   if (AW < 3) begin : g_bad_aw
      $error("lbus_cycle_seq: AW must be at least 3");
   end
   if (CW < 1) begin : g_bad_cw
      $error("lbus_cycle_seq: CW must be at least 1");
   end
   if (BURST_WORDS < 1) begin : g_bad_bw
      $error("lbus_cycle_seq: BURST_WORDS must be at least 1");
   end

   lbs_state_e    st, st_nxt;
   logic [1:0]    c_width;
   logic [WW-1:0] c_wait;
   logic          c_rdy, c_bterm, c_burst, c_write;

   logic           accept;
   logic           beat_done, end_cycle, cap_hit, wait_over;
   logic           last_word, last_all;
   logic [AW-1:0]  cur_addr;
   logic [BCW-1:0] burst_beats, cap_m1;

   assign accept = req_valid && (st == ST_IDLE);

   // capture settings only when a request is taken
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_width <= 2'b10;
         c_wait  <= '0;
         c_rdy   <= 1'b0;
         c_bterm <= 1'b0;
         c_burst <= 1'b0;
         c_write <= 1'b0;
      end else if (accept) begin
         c_width <= cfg_width;
         c_wait  <= cfg_wait;
         c_rdy   <= cfg_rdy_en;
         c_bterm <= cfg_bterm_en;
         c_burst <= cfg_burst_en;
         c_write <= req_write;
      end
   end

   lbs_wait_timer #(.WW(WW), .WAIT_EN(WAIT_EN)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     ((st == ST_ADDR) || beat_done),
      .load_val (c_wait),
      .expired  (wait_over)
   );

   lbs_beat_track #(.AW(AW), .CW(CW), .BCW(BCW)) u_track (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (accept),
      .start_addr     (req_addr),
      .start_words    (req_words),
      .width          (c_width),
      .beat_done      (beat_done),
      .new_cycle      (end_cycle),
      .cur_addr       (cur_addr),
      .last_beat_word (last_word),
      .last_beat_all  (last_all),
      .burst_beats    (burst_beats)
   );

   assign cap_m1  = BCW'(BURST_WORDS) * BCW'(beats_per_word(c_width)) - BCW'(1);
   assign cap_hit = (burst_beats == cap_m1);

   assign beat_done = (st == ST_DATA) && wait_over && (!c_rdy || lb_rdy) && usr_valid;
   assign end_cycle = !c_burst || (!c_bterm && cap_hit) || (c_bterm && lb_bterm);

   always_comb begin
      st_nxt = st;
      case (st)
         ST_IDLE: if (accept) st_nxt = (req_words == '0) ? ST_FIN : ST_ADDR;
         ST_ADDR: st_nxt = ST_DATA;
         ST_DATA: begin
            if (beat_done) begin
               if (last_all)       st_nxt = ST_FIN;
               else if (end_cycle) st_nxt = ST_ADDR;
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nxt;
   end

   assign req_ready = (st == ST_IDLE);
   assign lb_ads    = (st == ST_ADDR);
   assign lb_dv     = (st == ST_DATA);
   assign lb_addr   = cur_addr;
   assign lb_write  = c_write;
   assign lb_last   = (st == ST_DATA) && (last_all || !c_burst || (!c_bterm && cap_hit));
   assign usr_ack   = beat_done && last_word;
   assign done      = (st == ST_FIN);

   // R6: an address strobe lasts one cycle and is followed by data
   assert_ads_then_data_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      lb_ads |=> (lb_dv && !lb_ads));

   // R2: with a nonzero wait count the first data cycle cannot finish
   assert_wait_first_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (WAIT_EN && lb_ads && c_wait != '0) |=> (lb_dv && !usr_ack));

   // R3: a stalled phase keeps its address and stays in data
   assert_rdy_stall_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (lb_dv && c_rdy && !lb_rdy) |=> (lb_dv && $stable(lb_addr)));

   // R4: the beat count in one bus cycle stays under the limit
   assert_burst_cap_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (lb_dv && !c_bterm) |-> (burst_beats <= cap_m1));

   // R5: a terminated beat with work left leads to a fresh address phase
   assert_bterm_readdr_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (beat_done && c_bterm && lb_bterm && !last_all) |=> lb_ads);

   // R9: done is a single pulse followed by idle
   assert_done_pulse_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (req_ready && !done));

   // R10: captured settings hold while a request is in flight
   assert_cfg_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |=> ($stable(c_width) && $stable(c_wait) && $stable(c_burst)
                           && $stable(c_bterm) && $stable(c_rdy) && $stable(c_write)));

   // R8: the word acknowledge is never asserted outside a data phase
   assert_ack_in_data_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      usr_ack |-> lb_dv);

endmodule

// File: tb/sim_lbus_cycle_seq.sv
module sim_lbus_cycle_seq;

   localparam int AW = 32;
   localparam int CW = 8;
   localparam int WW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_width = 2'b10;
   logic [WW-1:0] cfg_wait = '0;
   logic          cfg_rdy_en = 1'b0, cfg_bterm_en = 1'b0, cfg_burst_en = 1'b1;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [CW-1:0] req_words = '0;
   logic          usr_valid = 1'b1, lb_rdy = 1'b0, lb_bterm = 1'b0;
   logic          req_ready, usr_ack, lb_ads, lb_dv, lb_last, lb_write, done;
   logic [AW-1:0] lb_addr;

   always #5 clk = ~clk;

   lbus_cycle_seq #(.AW(AW), .CW(CW), .WW(WW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_wait(cfg_wait),
      .cfg_rdy_en(cfg_rdy_en), .cfg_bterm_en(cfg_bterm_en), .cfg_burst_en(cfg_burst_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_words(req_words), .usr_valid(usr_valid),
      .usr_ack(usr_ack), .lb_ads(lb_ads), .lb_addr(lb_addr), .lb_write(lb_write),
      .lb_dv(lb_dv), .lb_last(lb_last), .lb_rdy(lb_rdy), .lb_bterm(lb_bterm),
      .done(done));

   int checks = 0;
   int errors = 0;
   int ads_cnt = 0;
   int ack_cnt = 0;
   bit rnd_rdy = 0, rnd_bt = 0, rnd_usr = 0;
   bit finished = 0;

   task automatic check(input string what, input string rq, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", rq, what, act, exp, $time);
      end
   endtask

   // background input patterns, changed just after each rising edge
   always @(posedge clk) begin
      #2;
      if (rnd_rdy) lb_rdy    <= ($urandom % 3) != 0;
      if (rnd_bt)  lb_bterm  <= ($urandom % 5) == 0;
      if (rnd_usr) usr_valid <= ($urandom % 4) != 0;
   end

   // behavioural reference: 0 idle, 1 address, 2 data, 3 finish
   int ms = 0;
   longint m_addr = 0;
   int m_bidx, m_wleft, m_bcnt, m_wt;
   int m_w, m_wait, m_bpw;
   bit m_rdy, m_bt, m_bu, m_wr;

   always @(negedge clk) begin
      if (!rst_n) begin
         ms = 0;
      end else begin
         bit pe, lastw, lastall, capend, endc;
         int step;
         step    = 4 / (m_bpw == 0 ? 1 : m_bpw);
         pe      = (ms == 2) && (m_wt >= m_wait) && (!m_rdy || lb_rdy) && usr_valid;
         lastw   = (m_bidx == m_bpw - 1);
         lastall = lastw && (m_wleft == 1);
         capend  = !m_bt && (m_bcnt == 4 * m_bpw - 1);
         endc    = !m_bu || capend || (m_bt && lb_bterm);
         check("req_ready", "R9", req_ready, ms == 0);
         check("lb_ads", "R4 R5 R6", lb_ads, ms == 1);
         check("lb_dv", "R2 R3", lb_dv, ms == 2);
         check("done", "R9", done, ms == 3);
         check("usr_ack", "R8", usr_ack, pe && lastw);
         check("lb_last", "R7", lb_last, (ms == 2) && (lastall || !m_bu || capend));
         if (ms == 1 || ms == 2) begin
            check("lb_addr", "R1", lb_addr, m_addr & 64'hFFFF_FFFF);
            check("lb_write", "R10", lb_write, m_wr);
         end
         if (lb_ads) ads_cnt++;
         if (usr_ack) ack_cnt++;
         case (ms)
            0: if (req_valid) begin
               m_w = cfg_width; m_wait = cfg_wait; m_rdy = cfg_rdy_en;
               m_bt = cfg_bterm_en; m_bu = cfg_burst_en; m_wr = req_write;
               m_bpw = (m_w == 0) ? 4 : (m_w == 1) ? 2 : 1;
               m_addr = req_addr; m_bidx = 0; m_wleft = req_words; m_bcnt = 0;
               ms = (req_words == 0) ? 3 : 1;
            end
            1: begin ms = 2; m_wt = 0; end
            2: if (pe) begin
               m_addr = m_addr + (4 / m_bpw);
               if (lastw) begin m_bidx = 0; m_wleft--; end
               else m_bidx++;
               if (lastall) ms = 3;
               else if (endc) begin ms = 1; m_bcnt = 0; end
               else begin m_bcnt++; m_wt = 0; end
            end else m_wt++;
            default: ms = 0;
         endcase
      end
   end

   task automatic set_cfg(input int w, input int wt, input bit rdy, input bit bt, input bit bu);
      cfg_width = 2'(w); cfg_wait = WW'(wt);
      cfg_rdy_en = rdy; cfg_bterm_en = bt; cfg_burst_en = bu;
   endtask

   task automatic run_req(input longint a, input int words, input bit wr, input bit disturb);
      @(posedge clk); #2;
      ads_cnt = 0; ack_cnt = 0;
      req_valid = 1'b1; req_addr = AW'(a); req_words = CW'(words); req_write = wr;
      @(posedge clk); #2;
      req_valid = 1'b0;
      if (disturb) begin
         cfg_width = ~cfg_width; cfg_wait = ~cfg_wait;
         cfg_burst_en = ~cfg_burst_en; cfg_bterm_en = ~cfg_bterm_en;
         req_write = ~req_write;
      end
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done) break;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R11: idle outputs after reset
      check("reset req_ready", "R11", req_ready, 1);
      check("reset lb_ads", "R11", lb_ads, 0);
      check("reset lb_dv", "R11", lb_dv, 0);
      check("reset done", "R11", done, 0);
      check("reset usr_ack", "R11", usr_ack, 0);
      check("reset lb_last", "R11", lb_last, 0);

      // R4: six full-width words split into 4 + 2
      set_cfg(2, 0, 0, 0, 1);
      run_req(32'h1000, 6, 1, 0);
      check("R4 address phases for 6 words", "R4", ads_cnt, 2);
      check("R8 word acks for 6 words", "R8", ack_cnt, 6);

      // R1 R2: byte port, two waits, two words fit one burst
      set_cfg(0, 2, 0, 0, 1);
      run_req(32'h2003, 2, 0, 0);
      check("R1 address phases byte port", "R1", ads_cnt, 1);
      check("R2 word acks with waits", "R2", ack_cnt, 2);

      // R6: halfword port, bursting off, 3 words -> 6 beats
      set_cfg(1, 1, 0, 0, 0);
      run_req(32'h3000, 3, 1, 0);
      check("R6 one strobe per beat", "R6", ads_cnt, 6);

      // R3 R5 R8: random ready, terminate and requester stalls
      rnd_rdy = 1; rnd_bt = 1; rnd_usr = 1;
      set_cfg(2, 1, 1, 1, 1);
      run_req(32'h4000, 10, 0, 0);
      check("R8 acks under stalls", "R8", ack_cnt, 10);
      set_cfg(0, 0, 1, 1, 1);
      run_req(32'h4100, 3, 1, 0);
      check("R3 acks byte port random ready", "R3", ack_cnt, 3);
      rnd_rdy = 0; rnd_bt = 0; rnd_usr = 0;
      @(posedge clk); #2 usr_valid = 1'b1; lb_rdy = 1'b0;

      // R5: terminate input held high but disabled -> ignored
      lb_bterm = 1'b1;
      set_cfg(2, 0, 0, 0, 1);
      run_req(32'h5000, 8, 0, 0);
      check("R5 disabled terminate ignored", "R5", ads_cnt, 2);
      // R5: enabled terminate held high -> one beat per bus cycle
      set_cfg(2, 0, 0, 1, 1);
      run_req(32'h5100, 3, 0, 0);
      check("R5 terminate splits every beat", "R5", ads_cnt, 3);
      lb_bterm = 1'b0;

      // R10: settings scrambled right after acceptance
      set_cfg(3, 1, 0, 0, 1);
      run_req(32'h6000, 5, 1, 1);
      check("R10 strobes with captured settings", "R10", ads_cnt, 2);

      // R9: zero-word request
      set_cfg(2, 0, 0, 0, 1);
      run_req(32'h7000, 0, 0, 0);
      check("R9 zero words no strobe", "R9", ads_cnt, 0);

      // R7: 16-bit burst, last flag counted via model every cycle
      set_cfg(1, 0, 0, 0, 1);
      run_req(32'h8000, 5, 0, 0);
      check("R7 strobes halfword 5 words", "R7", ads_cnt, 2);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule